// File: doc/BRIEF.md
# Trap Return Address Register

This block holds the machine-level address that an exception return jumps back to. A trap writes the faulting program counter into it. Software can also read and write it through a CSR port. It has two outputs. The CSR read value feeds explicit register reads. The return target feeds the exception-return instruction. Both outputs show the stored value through the same alignment mask, so a return always lands on a legal instruction boundary. This holds even when software copies a trap-vector base, with its low mode bits set, into the register.

The parameter `ALIGN_SWITCHABLE` chooses between two builds:
- **Fixed build (`ALIGN_SWITCHABLE`=0):** the design supports only 32-bit instruction alignment. The two low bits are hardwired to zero.
- **Switchable build (`ALIGN_SWITCHABLE`=1):** the design can switch between 16-bit and 32-bit alignment at run time. Bit 0 is hardwired to zero and bit 1 is stored. The input `align32_sel` chooses the current mode, and while it is high, bit 1 is hidden on both outputs. The stored bit 1 is still written while it is hidden, and it shows again once 16-bit alignment is chosen.

The output mask depends combinationally on the mode input, so a mode change shows on both outputs in the same cycle.

Top module: `epc_reg`

## Requirements
- R1: After a synchronous active-high reset, `csr_rdata` and `ret_target` are all zeros.
- R2: Bit 0 of `csr_rdata` and `ret_target` is always 0, whatever was written or captured.
- R3: In the switchable build with `align32_sel`=1, bit 1 of both outputs reads 0.
- R4: In the switchable build with `align32_sel`=0, bit 1 of both outputs equals the bit 1 that was last written or captured.
- R5: A write made while `align32_sel`=1 still updates the stored bit 1. That bit appears on both outputs in the same cycle that `align32_sel` falls to 0.
- R6: When `trap_capture` and `csr_we` are both high in one cycle, the register takes `trap_pc` and ignores `csr_wdata`.
- R7: `ret_target` always equals `csr_rdata`.
- R8: Bits XLEN-1..2 of a CSR write or a trap capture appear unchanged on both outputs from the next cycle on. This also covers a trap-vector base value with mode bits 1..0 = 01, which returns an aligned address.
- R9: In the fixed build, bits 1..0 of both outputs are always 0, whatever the value of `align32_sel`.
- R10: In a cycle with neither `csr_we` nor `trap_capture` high, the stored value does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | CSR write enable |
| csr_wdata | input | XLEN | CSR write data |
| trap_capture | input | 1 | Load the faulting PC |
| trap_pc | input | XLEN | Faulting PC |
| align32_sel | input | 1 | 1 = 32-bit alignment active (used only by the switchable build) |
| csr_rdata | output | XLEN | Masked value for explicit reads |
| ret_target | output | XLEN | Masked jump target for the exception return |

## Verification
The bench writes values with bits 1..0 set while the mode changes. Two designs would fail here:
- A design that masks bit 1 at write time would lose the bit when 16-bit alignment comes back.
- A design that masks only the read path would return to a misaligned address.

It copies a vectored-mode base into the register and checks that the return target is aligned. It also raises a trap and a CSR write in the same cycle, which exposes any priority inversion. A second instance built for fixed 32-bit alignment toggles the mode input, which catches a fixed build that leaks bit 1.

// File: rtl/epc_pkg.sv
package epc_pkg;

    // Which source loads the register in a cycle
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_TRAP = 2'd1,
        SRC_CSR  = 2'd2
    } epc_src_e;

    typedef enum logic {
        ALIGN_16 = 1'b0,
        ALIGN_32 = 1'b1
    } align_e;

    // Low-bit keep mask for storage: bit 0 is never kept, and bit 1 is kept only if switchable
    function automatic logic [1:0] store_keep(input logic switchable);
        return switchable ? 2'b10 : 2'b00;
    endfunction

    // Low-bit keep mask for the visible value
    function automatic logic [1:0] view_keep(input logic switchable, input align_e mode);
        return (switchable && mode == ALIGN_16) ? 2'b10 : 2'b00;
    endfunction

    function automatic epc_src_e pick_src(input logic trap, input logic we);
        if (trap)
            return SRC_TRAP;
        else if (we)
            return SRC_CSR;
        else
            return SRC_HOLD;
    endfunction

endpackage

// File: rtl/epc_store.sv
module epc_store
    import epc_pkg::*;
#(
    parameter int XLEN             = 64,
    parameter bit ALIGN_SWITCHABLE = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            trap_capture,
    input  logic [XLEN-1:0] trap_pc,
    output logic [XLEN-1:0] stored
);
    localparam int UPPER = XLEN - 2;

    epc_src_e   src;
    logic [XLEN-1:0] next_raw;
    logic [XLEN-1:0] next_legal;
    logic [1:0]      keep;

    always_comb begin
        src  = pick_src(trap_capture, csr_we);
        keep = store_keep(ALIGN_SWITCHABLE);
        unique case (src)
            SRC_TRAP: next_raw = trap_pc;
            SRC_CSR:  next_raw = csr_wdata;
            default:  next_raw = stored;
        endcase
        next_legal = {next_raw[XLEN-1:2], next_raw[1:0] & keep};
    end

    always_ff @(posedge clk) begin
        if (rst)
            stored <= '0;
        else if (src != SRC_HOLD)
            stored <= next_legal;
    end

    logic [UPPER-1:0] unused_upper;
    assign unused_upper = stored[XLEN-1:2];

endmodule

// File: rtl/epc_view.sv
module epc_view
    import epc_pkg::*;
#(
    parameter int XLEN             = 64,
    parameter bit ALIGN_SWITCHABLE = 1'b1
) (
    input  logic [XLEN-1:0] stored,
    input  logic            align32_sel,
    output logic [XLEN-1:0] visible
);
    align_e     mode;
    logic [1:0] keep;

    always_comb begin
        mode    = align_e'(align32_sel);
        keep    = view_keep(ALIGN_SWITCHABLE, mode);
        visible = {stored[XLEN-1:2], stored[1:0] & keep};
    end

endmodule

// File: rtl/epc_reg.sv
module epc_reg
    import epc_pkg::*;
#(
    parameter int XLEN             = 64,
    parameter bit ALIGN_SWITCHABLE = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            trap_capture,
    input  logic [XLEN-1:0] trap_pc,
    input  logic            align32_sel,
    output logic [XLEN-1:0] csr_rdata,
    output logic [XLEN-1:0] ret_target
);
    logic [XLEN-1:0] stored;
    logic [XLEN-1:0] views [2];

    epc_store #(.XLEN(XLEN), .ALIGN_SWITCHABLE(ALIGN_SWITCHABLE)) u_store (
        .clk          (clk),
        .rst          (rst),
        .csr_we       (csr_we),
        .csr_wdata    (csr_wdata),
        .trap_capture (trap_capture),
        .trap_pc      (trap_pc),
        .stored       (stored)
    );

    // One view for the explicit read path, one for the return path
    for (genvar g = 0; g < 2; g++) begin : g_view
        epc_view #(.XLEN(XLEN), .ALIGN_SWITCHABLE(ALIGN_SWITCHABLE)) u_view (
            .stored      (stored),
            .align32_sel (align32_sel),
            .visible     (views[g])
        );
    end

    assign csr_rdata  = views[0];
    assign ret_target = views[1];

endmodule

// File: rtl/epc_reg_chk.sv
module epc_reg_chk #(
    parameter int XLEN             = 64,
    parameter bit ALIGN_SWITCHABLE = 1'b1
) (
    input logic            clk,
    input logic            rst,
    input logic            csr_we,
    input logic [XLEN-1:0] csr_wdata,
    input logic            trap_capture,
    input logic [XLEN-1:0] trap_pc,
    input logic            align32_sel,
    input logic [XLEN-1:0] csr_rdata,
    input logic [XLEN-1:0] ret_target
);
    // R2
    bit0_zero_chk: assert property (@(posedge clk) disable iff (rst)
        csr_rdata[0] == 1'b0 && ret_target[0] == 1'b0);

    // R7
    ret_match_chk: assert property (@(posedge clk) disable iff (rst)
        ret_target == csr_rdata);

    // R3
    bit1_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        (ALIGN_SWITCHABLE && align32_sel) |-> (csr_rdata[1] == 1'b0 && ret_target[1] == 1'b0));

    // R9
    fixed_low_chk: assert property (@(posedge clk) disable iff (rst)
        !ALIGN_SWITCHABLE |-> (csr_rdata[1:0] == 2'b00));

    // R6
    trap_wins_chk: assert property (@(posedge clk) disable iff (rst)
        trap_capture |=> csr_rdata[XLEN-1:2] == $past(trap_pc[XLEN-1:2]));

    // R8
    write_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_we && !trap_capture) |=> csr_rdata[XLEN-1:2] == $past(csr_wdata[XLEN-1:2]));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!csr_we && !trap_capture) |=> $stable(csr_rdata[XLEN-1:2]));

endmodule

bind epc_reg epc_reg_chk #(.XLEN(XLEN), .ALIGN_SWITCHABLE(ALIGN_SWITCHABLE)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .csr_we       (csr_we),
    .csr_wdata    (csr_wdata),
    .trap_capture (trap_capture),
    .trap_pc      (trap_pc),
    .align32_sel  (align32_sel),
    .csr_rdata    (csr_rdata),
    .ret_target   (ret_target)
);

// File: tb/epc_reg_bench.sv
`timescale 1ns/1ps
module epc_reg_bench;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            csr_we = 1'b0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic            trap_capture = 1'b0;
    logic [XLEN-1:0] trap_pc = '0;
    logic            align32_sel = 1'b0;
    logic [XLEN-1:0] rd_sw, rt_sw, rd_fx, rt_fx;

    int total = 0;
    int bad   = 0;
    string tag = "R1";
    bit done = 1'b0;

    logic [XLEN-1:0] m_sw = '0;
    logic [XLEN-1:0] m_fx = '0;

    always #10 clk = ~clk;

    epc_reg #(.XLEN(XLEN), .ALIGN_SWITCHABLE(1'b1)) u_epc_reg (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .trap_capture(trap_capture), .trap_pc(trap_pc), .align32_sel(align32_sel),
        .csr_rdata(rd_sw), .ret_target(rt_sw));

    epc_reg #(.XLEN(XLEN), .ALIGN_SWITCHABLE(1'b0)) u_epc_reg_fixed (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .trap_capture(trap_capture), .trap_pc(trap_pc), .align32_sel(align32_sel),
        .csr_rdata(rd_fx), .ret_target(rt_fx));

    // Behavioural reference: what the register should hold
    always @(posedge clk) begin
        logic [XLEN-1:0] v;
        if (rst) begin
            m_sw = '0;
            m_fx = '0;
        end else if (trap_capture || csr_we) begin
            v = trap_capture ? trap_pc : csr_wdata;
            m_sw = v & ~64'd1;
            m_fx = v & ~64'd3;
        end
    end

    function automatic logic [XLEN-1:0] vis_sw(input logic [XLEN-1:0] m, input logic a32);
        return a32 ? (m & ~64'd2) : m;
    endfunction

    task automatic check(input string t, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    // Compared on every cycle, away from the rising edge
    always @(negedge clk) begin
        if (!done) begin
            check({tag, " read"},  rd_sw, vis_sw(m_sw, align32_sel));
            check({tag, " ret"},   rt_sw, vis_sw(m_sw, align32_sel));
            check({tag, " fixed"}, rd_fx, m_fx);
            check({tag, " fixed ret"}, rt_fx, m_fx);
        end
    end

    task automatic drive(input logic we, input logic [XLEN-1:0] wd,
                         input logic tr, input logic [XLEN-1:0] pc, input logic a32);
        @(posedge clk);
        #1;
        csr_we = we; csr_wdata = wd; trap_capture = tr; trap_pc = pc; align32_sel = a32;
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 reset read", rd_sw, '0);
        check("R1 reset ret",  rt_sw, '0);

        // R4: 16-bit mode shows bit 1, R2 bit 0 dropped
        tag = "R4";
        drive(1, 64'h1234_5678_9abc_def3, 0, '0, 0);
        drive(0, '0, 0, '0, 0);
        @(negedge clk);
        check("R4 bit1 visible", rd_sw, 64'h1234_5678_9abc_def2);
        tag = "R2";
        check("R2 bit0 zero", {63'd0, rd_sw[0]}, '0);

        // R3: 32-bit mode hides bit 1 on both paths
        tag = "R3";
        drive(0, '0, 0, '0, 1);
        @(negedge clk);
        check("R3 read masked", rd_sw, 64'h1234_5678_9abc_def0);
        check("R3 ret masked",  rt_sw, 64'h1234_5678_9abc_def0);

        // R5: write under 32-bit mode, then reveal
        tag = "R5";
        drive(1, 64'hffff_0000_0000_1006, 0, '0, 1);
        drive(0, '0, 0, '0, 1);
        @(negedge clk);
        check("R5 hidden", rd_sw, 64'hffff_0000_0000_1004);
        drive(0, '0, 0, '0, 0);
        @(negedge clk);
        check("R5 revealed same cycle", rt_sw, 64'hffff_0000_0000_1006);

        // R8: vectored base copied in, return must be aligned
        tag = "R8";
        drive(1, 64'h0000_0000_8000_0101, 0, '0, 1);
        drive(0, '0, 0, '0, 1);
        @(negedge clk);
        check("R8 vectored base ret", rt_sw, 64'h0000_0000_8000_0100);
        check("R8 fixed build ret",   rt_fx, 64'h0000_0000_8000_0100);

        // R6: trap beats CSR write
        tag = "R6";
        drive(1, 64'hdead_beef_dead_beef, 1, 64'h0000_0000_0040_0012, 0);
        drive(0, '0, 0, '0, 0);
        @(negedge clk);
        check("R6 trap wins", rd_sw, 64'h0000_0000_0040_0012);

        // R10: idle cycles hold the value while mode toggles
        tag = "R10";
        for (int i = 0; i < 8; i++) drive(0, 64'hffff_ffff_ffff_ffff, 0, 64'h5555, i[0]);
        drive(0, '0, 0, '0, 0);
        @(negedge clk);
        check("R10 held", rd_sw, 64'h0000_0000_0040_0012);

        // R9: fixed build ignores the mode input; R7 paths agree
        tag = "R9";
        for (int i = 0; i < 16; i++)
            drive(1, {i[31:0], 32'h0000_0003} ^ (64'h1 << i), i[1], {32'hcafe, i[31:0]} | 64'h2, i[2]);
        tag = "R7";
        for (int i = 0; i < 16; i++)
            drive(i[0], 64'h0f0f_0000_0000_0003 + i, i[1], 64'h7 * i, i[3]);
        drive(0, '0, 0, '0, 0);
        @(negedge clk);
        check("R7 ret equals read", rt_sw, rd_sw);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule